// File: doc/BRIEF.md
# MDIO Management Frame Responder

This block plays the PHY side of Clause-22 style management frames whose lines are toggled by software through a small control register instead of real pins. Software writes the register with a clock level, a data level and a drive-enable flag. The block treats every low-to-high change of the written clock level as one serial bit time. It finds the preamble, decodes the frame header and then does one of two things. It captures a 16-bit write word into a local register bank, or it streams a 16-bit read word back through a read-only bit of the same control register.

The register bank holds 32 words of 16 bits. After reset every word is zero except the two identifier words. The bank can be built read-only by a parameter, so that management writes are decoded but thrown away. The PHY address field is decoded but not compared: the block answers every address.

Top module: `mdio_resp_top`

## Requirements
- R1: The control register holds data-out in bit 0, the returned data-in bit in bit 1, drive-enable in bit 2 and the software clock in bit 3. A write updates bits 0, 2 and 3, which read back as written on the next cycle. A write never changes bit 1.
- R2: One bit is sampled only when a write takes the clock bit from 0 to 1. The sampled value is data-out AND drive-enable. Writes that keep the clock high sample nothing.
- R3: Thirty-two consecutive sampled ones synchronise the receiver. This also applies in the middle of a broken frame, and the first 0 after the ones is the first start bit.
- R4: The 16 bits after synchronisation form the header, MSB first: start[15:14], opcode[13:12], PHY address[11:7], register address[6:2], turnaround[1:0]. Start 01 with opcode 01 and turnaround 10 is a write. The next 16 sampled bits, MSB first, are stored into the addressed register.
- R5: Start 01 with opcode 10 is a read when turnaround bit 0 is 0, whatever turnaround bit 1 holds. When turnaround bit 0 is 1 the frame is ignored and data-in keeps its value.
- R6: In a read, the 16 rising clock edges after the header each put one bit of the addressed register on data-in, MSB first, visible right after that edge. Data-in then holds until the next read.
- R7: A header with any other start, opcode or turnaround value is ignored and leaves the bank unchanged.
- R8: After reset the control register reads 0. Register 2 holds 0x0022, register 3 holds 0x161A, and all other registers hold 0.
- R9: With the write-enable parameter cleared, decoded writes are discarded and reads keep returning the reset contents.
- R10: The PHY address field does not select whether the block answers; every address value is served.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_we | input | 1 | Software write strobe for the control register |
| sw_wdata | input | 4 | Value written to the control register |
| sw_rdata | output | 4 | Current control register value including data-in |

## Verification
Two instances, one writable and one read-only, receive the same bit-banged frames, and every register is swept with an arithmetic pattern while the PHY address changes with each frame. A run with both variants shows whether the write phase lands in the right word and in the right bit order. Malformed headers are each sent once, one for every field that can be wrong. These are a bad start code, a bad opcode and a bad write turnaround, plus a read turnaround with its low bit set. Each one must leave the bank and data-in untouched, which separates the decode checks from one another. Frames sent with drive-enable low, frames with repeated clock-high writes, resync after junk bits and a software write in the middle of a read show the edge sampling and the read-only data-in bit.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;

    localparam int CTRL_W  = 4;
    localparam int BIT_DO  = 0;
    localparam int BIT_DI  = 1;
    localparam int BIT_OE  = 2;
    localparam int BIT_CLK = 3;

    localparam logic [1:0] ST_CODE  = 2'b01;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] TA_WRITE = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_READ  = 2'd1,
        PH_WRITE = 2'd2
    } phase_e;

endpackage

// File: rtl/mdio_resp_frame.sv
module mdio_resp_frame
    import mdio_resp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              mclk_i,
    input  logic              mdo_i,
    input  logic              moe_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              di_o
);

    localparam int SHIFT_W = 2 * DATA_W;
    localparam int CNT_W   = $clog2(SHIFT_W + 2);
    localparam int RA_LO   = 2;
    localparam int PA_LO   = RA_LO + ADDR_W;
    localparam int OP_LO   = PA_LO + ADDR_W;
    localparam int ST_LO   = OP_LO + 2;
    localparam logic [CNT_W-1:0] CNT_SYNC = CNT_W'(SHIFT_W);
    localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] CNT_EXP  = '1;

    typedef struct packed {
        logic               last_clk;
        logic [SHIFT_W-1:0] shreg;
        logic [CNT_W-1:0]   cnt;
        phase_e             phase;
        logic [ADDR_W-1:0]  reg_addr;
        logic [DATA_W-1:0]  dout;
        logic               di;
    } frame_t;

    frame_t frm_d, frm_q;

    logic               rise;
    logic               samp;
    logic [SHIFT_W-1:0] shifted;
    logic [CNT_W-1:0]   cnt_v;
    phase_e             phase_v;
    logic [1:0]         hdr_st, hdr_op, hdr_ta;

    assign rise    = we_i && !frm_q.last_clk && mclk_i;
    assign samp    = mdo_i & moe_i;
    assign shifted = {frm_q.shreg[SHIFT_W-2:0], samp};
    assign hdr_st  = shifted[ST_LO +: 2];
    assign hdr_op  = shifted[OP_LO +: 2];
    assign hdr_ta  = shifted[1:0];

    always_comb begin
        frm_d     = frm_q;
        cnt_v     = frm_q.cnt;
        phase_v   = frm_q.phase;
        wr_en_o   = 1'b0;
        rd_addr_o = shifted[RA_LO +: ADDR_W];
        wr_addr_o = frm_q.reg_addr;
        wr_data_o = shifted[DATA_W-1:0];

        if (we_i) begin
            frm_d.last_clk = mclk_i;
        end

        if (rise) begin
            frm_d.shreg = shifted;
            if (&shifted) begin
                cnt_v = CNT_SYNC;
            end

            if (cnt_v == CNT_HALF) begin
                if (hdr_st == ST_CODE && hdr_op == OP_WRITE && hdr_ta == TA_WRITE) begin
                    phase_v = PH_WRITE;
                end else if (hdr_st == ST_CODE && hdr_op == OP_READ && !hdr_ta[0]) begin
                    phase_v = PH_READ;
                end else begin
                    phase_v = PH_IDLE;
                end
                if (phase_v != PH_IDLE) begin
                    frm_d.reg_addr = shifted[RA_LO +: ADDR_W];
                end
                if (phase_v == PH_READ) begin
                    frm_d.dout = rd_data_i;
                end
            end else if (cnt_v < CNT_HALF && phase_v == PH_READ) begin
                frm_d.di   = frm_q.dout[DATA_W-1];
                frm_d.dout = {frm_q.dout[DATA_W-2:0], 1'b0};
            end

            if (cnt_v == '0 && phase_v != PH_IDLE) begin
                wr_en_o = (phase_v == PH_WRITE);
                phase_v = PH_IDLE;
            end

            frm_d.cnt   = (cnt_v == '0 || cnt_v == CNT_EXP) ? CNT_EXP : cnt_v - 1'b1;
            frm_d.phase = phase_v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q          <= '0;
            frm_q.cnt      <= CNT_EXP;
            frm_q.phase    <= PH_IDLE;
        end else begin
            frm_q <= frm_d;
        end
    end

    assign di_o = frm_q.di;

    // R6
    di_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && mclk_i && !frm_q.last_clk) |=> $stable(di_o));

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q.cnt <= CNT_SYNC) || (frm_q.cnt == CNT_EXP));

    // R7
    busy_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frm_q.phase != PH_IDLE) |-> (frm_q.cnt < CNT_HALF));

endmodule

// File: rtl/mdio_resp_bank.sv
module mdio_resp_bank #(
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 5,
    parameter int          NUM_REGS  = 32,
    parameter bit          WRITE_EN  = 1'b1,
    parameter int          ID_HI_IDX = 2,
    parameter int          ID_LO_IDX = 3,
    parameter logic [15:0] ID_HI_VAL = 16'h0022,
    parameter logic [15:0] ID_LO_VAL = 16'h161A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i
);

    localparam logic [ADDR_W:0] NREG = (ADDR_W + 1)'(NUM_REGS);

    logic [NUM_REGS-1:0][DATA_W-1:0] regs_d, regs_q;

    function automatic logic [DATA_W-1:0] init_val(input int idx);
        if (idx == ID_HI_IDX) return DATA_W'(ID_HI_VAL);
        if (idx == ID_LO_IDX) return DATA_W'(ID_LO_VAL);
        return '0;
    endfunction

    generate
        if (WRITE_EN) begin : g_rw
            always_comb begin
                regs_d = regs_q;
                if (wr_en_i && ({1'b0, wr_addr_i} < NREG)) begin
                    regs_d[wr_addr_i] = wr_data_i;
                end
            end

            // R4
            wr_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
                wr_en_i |=> (regs_q[$past(wr_addr_i)] == $past(wr_data_i)));
        end else begin : g_ro
            always_comb begin
                regs_d = regs_q;
            end

            // R9
            ro_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $stable(regs_q));
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs_q[i] <= init_val(i);
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd_data_o = ({1'b0, rd_addr_i} < NREG) ? regs_q[rd_addr_i] : '0;

    logic wr_unused;
    assign wr_unused = wr_en_i & ~WRITE_EN;

endmodule

// File: rtl/mdio_resp_top.sv
module mdio_resp_top
    import mdio_resp_pkg::*;
#(
    parameter int          DATA_W    = 16,
    parameter int          ADDR_W    = 5,
    parameter int          NUM_REGS  = 32,
    parameter bit          WRITE_EN  = 1'b1,
    parameter logic [15:0] ID_HI_VAL = 16'h0022,
    parameter logic [15:0] ID_LO_VAL = 16'h161A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_we,
    input  logic [CTRL_W-1:0] sw_wdata,
    output logic [CTRL_W-1:0] sw_rdata
);

    typedef struct packed {
        logic mclk;
        logic moe;
        logic mdo;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;

    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              di;
    logic              sw_di_unused;

    assign sw_di_unused = sw_wdata[BIT_DI];

    always_comb begin
        ctrl_d = ctrl_q;
        if (sw_we) begin
            ctrl_d.mclk = sw_wdata[BIT_CLK];
            ctrl_d.moe  = sw_wdata[BIT_OE];
            ctrl_d.mdo  = sw_wdata[BIT_DO];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    always_comb begin
        sw_rdata          = '0;
        sw_rdata[BIT_DO]  = ctrl_q.mdo;
        sw_rdata[BIT_DI]  = di;
        sw_rdata[BIT_OE]  = ctrl_q.moe;
        sw_rdata[BIT_CLK] = ctrl_q.mclk;
    end

    mdio_resp_frame #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (sw_we),
        .mclk_i    (sw_wdata[BIT_CLK]),
        .mdo_i     (sw_wdata[BIT_DO]),
        .moe_i     (sw_wdata[BIT_OE]),
        .rd_data_i (rd_data),
        .rd_addr_o (rd_addr),
        .wr_en_o   (wr_en),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .di_o      (di)
    );

    mdio_resp_bank #(
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .NUM_REGS  (NUM_REGS),
        .WRITE_EN  (WRITE_EN),
        .ID_HI_IDX (2),
        .ID_LO_IDX (3),
        .ID_HI_VAL (ID_HI_VAL),
        .ID_LO_VAL (ID_LO_VAL)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data)
    );

    // R1
    ctrl_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we |=> (sw_rdata[BIT_DO]  == $past(sw_wdata[BIT_DO]))
               && (sw_rdata[BIT_OE]  == $past(sw_wdata[BIT_OE]))
               && (sw_rdata[BIT_CLK] == $past(sw_wdata[BIT_CLK])));

endmodule

// File: tb/mdio_resp_top_tb.sv
module mdio_resp_top_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_we = 1'b0;
    logic [3:0] sw_wdata = 4'h0;
    logic [3:0] rdata_rw, rdata_ro;

    int checks = 0;
    int errors = 0;

    logic drive_oe = 1'b1;
    logic dup_high = 1'b0;
    logic [15:0] exp_rw [32];

    always #2 clk = ~clk;

    mdio_resp_top #(.WRITE_EN(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(rdata_rw));

    mdio_resp_top #(.WRITE_EN(1'b0)) u_dut_ro (
        .clk(clk), .rst_n(rst_n), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(rdata_ro));

    function automatic logic [15:0] dflt(input int r);
        if (r == 2) return 16'h0022;
        if (r == 3) return 16'h161A;
        return 16'h0000;
    endfunction

    function automatic logic [15:0] patt(input int r);
        return 16'(r * 16'h0841) ^ 16'hA5C3;
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sw_write(input logic [3:0] v);
        @(negedge clk);
        sw_we = 1'b1;
        sw_wdata = v;
        @(negedge clk);
        sw_we = 1'b0;
    endtask

    task automatic send_bit(input logic b);
        sw_write({1'b0, drive_oe, 1'b0, b});
        sw_write({1'b1, drive_oe, 1'b0, b});
        if (dup_high) sw_write({1'b1, drive_oe, 1'b0, b});
    endtask

    task automatic preamble();
        for (int i = 0; i < 32; i++) send_bit(1'b1);
    endtask

    task automatic frame_wr(input logic [1:0] st, input logic [1:0] op, input logic [4:0] phy,
                            input logic [4:0] ra, input logic [1:0] ta, input logic [15:0] val);
        logic [31:0] w;
        w = {st, op, phy, ra, ta, val};
        preamble();
        for (int i = 31; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic frame_rd(input logic [4:0] phy, input logic [4:0] ra, input logic [1:0] ta,
                            output logic [15:0] got_rw, output logic [15:0] got_ro);
        logic [15:0] h;
        h = {2'b01, 2'b10, phy, ra, ta};
        preamble();
        for (int i = 15; i >= 0; i--) send_bit(h[i]);
        for (int i = 15; i >= 0; i--) begin
            sw_write({1'b0, 1'b0, 1'b0, 1'b0});
            sw_write({1'b1, 1'b0, 1'b0, 1'b0});
            got_rw[i] = rdata_rw[1];
            got_ro[i] = rdata_ro[1];
        end
    endtask

    initial begin : main
        logic [15:0] grw, gro;
        logic prev_rw, prev_ro;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R8 control register reset value
        check("R8 ctrl reset rw", {12'h0, rdata_rw}, 16'h0);
        check("R8 ctrl reset ro", {12'h0, rdata_ro}, 16'h0);

        // R1 data-in cannot be set by software
        sw_write(4'b0010);
        check("R1 di not settable", {12'h0, rdata_rw}, 16'h0);
        sw_write(4'b0101);
        check("R1 echo do/oe", {12'h0, rdata_rw}, 16'h0005);
        sw_write(4'b0000);

        // R8 reset contents, R10 varying phy address
        for (int r = 0; r < 32; r++) begin
            frame_rd(5'(r * 7), 5'(r), 2'b10, grw, gro);
            check($sformatf("R8 R6 reset read reg%0d rw", r), grw, dflt(r));
            check($sformatf("R8 reset read reg%0d ro", r), gro, dflt(r));
        end

        // R4 write sweep, R10 phy address ignored
        for (int r = 0; r < 32; r++) begin
            frame_wr(2'b01, 2'b01, 5'(r) ^ 5'h1F, 5'(r), 2'b10, patt(r));
            exp_rw[r] = patt(r);
        end
        for (int r = 0; r < 32; r++) begin
            frame_rd(5'(31 - r), 5'(r), 2'b10, grw, gro);
            check($sformatf("R4 R6 R10 readback reg%0d", r), grw, exp_rw[r]);
            check($sformatf("R9 ro readback reg%0d", r), gro, dflt(r));
        end

        // R5 relaxed turnaround on read
        frame_rd(5'd1, 5'd7, 2'b00, grw, gro);
        check("R5 read ta=00", grw, exp_rw[7]);

        // R5 read with turnaround bit0 set is ignored
        prev_rw = rdata_rw[1];
        prev_ro = rdata_ro[1];
        frame_rd(5'd1, 5'd5, 2'b01, grw, gro);
        check("R5 rejected read rw", grw, {16{prev_rw}});
        check("R5 rejected read ro", gro, {16{prev_ro}});

        // R7 malformed write headers
        frame_wr(2'b01, 2'b01, 5'd0, 5'd9, 2'b11, 16'h1234);
        frame_wr(2'b00, 2'b01, 5'd0, 5'd10, 2'b10, 16'h1234);
        frame_wr(2'b01, 2'b11, 5'd0, 5'd11, 2'b10, 16'h1234);
        frame_rd(5'd0, 5'd9, 2'b10, grw, gro);
        check("R7 bad ta write", grw, exp_rw[9]);
        frame_rd(5'd0, 5'd10, 2'b10, grw, gro);
        check("R7 bad start write", grw, exp_rw[10]);
        frame_rd(5'd0, 5'd11, 2'b10, grw, gro);
        check("R7 bad opcode write", grw, exp_rw[11]);

        // R2 drive-enable low samples zeros only
        drive_oe = 1'b0;
        frame_wr(2'b01, 2'b01, 5'd0, 5'd12, 2'b10, 16'h0F0F);
        drive_oe = 1'b1;
        frame_rd(5'd0, 5'd12, 2'b10, grw, gro);
        check("R2 oe low ignored", grw, exp_rw[12]);

        // R2 repeated clock-high writes sample once
        dup_high = 1'b1;
        frame_wr(2'b01, 2'b01, 5'd3, 5'd13, 2'b10, 16'hBEEF);
        dup_high = 1'b0;
        exp_rw[13] = 16'hBEEF;
        frame_rd(5'd0, 5'd13, 2'b10, grw, gro);
        check("R2 held clock", grw, 16'hBEEF);

        // R3 resync after junk bits
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b1); send_bit(1'b0);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
        frame_wr(2'b01, 2'b01, 5'd4, 5'd14, 2'b10, 16'h55AA);
        exp_rw[14] = 16'h55AA;
        frame_rd(5'd0, 5'd14, 2'b10, grw, gro);
        check("R3 resync write", grw, 16'h55AA);

        // R1 software cannot clear data-in during a read
        begin
            logic [15:0] h;
            h = {2'b01, 2'b10, 5'd0, 5'd13, 2'b10};
            preamble();
            for (int i = 15; i >= 0; i--) send_bit(h[i]);
            sw_write(4'b0000);
            sw_write(4'b1000);
            check("R6 first read bit", {15'h0, rdata_rw[1]}, 16'h0001);
            sw_write(4'b1000);
            check("R1 di kept rw", {12'h0, rdata_rw}, 16'h000A);
            check("R1 di kept ro", {12'h0, rdata_ro}, 16'h0008);
            sw_write(4'b1101);
            check("R1 echo with di", {12'h0, rdata_rw}, 16'h000F);
            for (int i = 14; i >= 0; i--) begin
                sw_write(4'b0000);
                sw_write(4'b1000);
            end
            check("R6 last read bit", {15'h0, rdata_rw[1]}, 16'(exp_rw[13][0]));
        end

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule